// File: doc/BRIEF.md
# Masked MAC address perfect filter

This block checks one address field of each received Ethernet frame against a single programmable 48-bit station address. It can match either the destination or the source field, and it can leave any of the six address bytes out of the comparison. Masking bytes lets one entry accept a whole group of addresses instead of a single station.

Software sets up the entry through a small register port in the configuration clock domain. The port has a high word and a low word. The high word holds the enable flag, the field select flag, six byte-mask flags and address bits 47:32. The low word holds address bits 31:0. A write to one specific byte lane of the low word copies the whole entry into the receive clock domain in a single step. The comparator therefore only ever works on a complete, consistent entry. For each frame, the receive logic supplies the destination and source fields, each with its own one-cycle strobe. The block answers with a registered result strobe and a match flag.

Top module: `mac_addr_filter`

## Requirements
- R1: After reset, the high word (cfg_addr=0) reads 0x0000FFFF and the low word (cfg_addr=1) reads 0xFFFFFFFF. A read returns the selected word one configuration clock after cfg_addr is presented.
- R2: The high word layout is: bit 31 enable, bit 30 source select, bits 29:24 byte masks, bits 15:0 address bits 47:32. The low word holds address bits 31:0. Each write updates only the bytes whose cfg_be bit is set.
- R3: Bits 23:16 of the high word always read as zero, and writes to them have no effect.
- R4: While the enable bit is clear in the transferred entry, rx_hit stays 0 for every frame.
- R5: With source select clear, the entry is compared with rx_da and the result follows rx_da_vld. With source select set, it is compared with rx_sa and the result follows rx_sa_vld. A strobe on the field that is not selected produces no result.
- R6: An enabled entry matches when every address byte whose mask bit is clear equals the same byte of the selected field. Mask bit 24+i covers address bits 8i+7:8i.
- R7: With all six mask bits set and the entry enabled, every frame matches.
- R8: A write to the low word with byte lane 3 enabled (cfg_big_endian=0), or with byte lane 0 enabled (cfg_big_endian=1), transfers the whole entry to the receive domain. Writes without the trigger lane leave the entry that the comparator uses unchanged. Successive trigger writes must be at least 4 receive clocks apart.
- R9: rx_hit_vld pulses exactly one receive clock after the selected field's strobe, and rx_hit is never 1 without rx_hit_vld.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cfg_clk | input | 1 | Configuration clock |
| cfg_rst | input | 1 | Synchronous active-high reset, configuration domain |
| cfg_wr | input | 1 | Register write strobe |
| cfg_addr | input | 1 | Word select: 0 high, 1 low |
| cfg_be | input | 4 | Byte enables for a write |
| cfg_wdata | input | 32 | Write data |
| cfg_big_endian | input | 1 | Selects which low-word byte lane triggers the transfer |
| cfg_rdata | output | 32 | Registered read data |
| rx_clk | input | 1 | Receive clock |
| rx_rst | input | 1 | Synchronous active-high reset, receive domain |
| rx_da | input | 48 | Destination address field of the frame |
| rx_da_vld | input | 1 | Destination field strobe |
| rx_sa | input | 48 | Source address field of the frame |
| rx_sa_vld | input | 1 | Source field strobe |
| rx_hit_vld | output | 1 | Result strobe |
| rx_hit | output | 1 | Match flag, meaningful with rx_hit_vld |

## Verification
Every one of the 64 mask values is programmed, and for each one the bench sends an exact copy of the station address plus six frames that each differ in one byte only. This separates bytes that are compared from bytes that are masked and exposes any swap in the mask-to-byte mapping. Further frames exercise the source/destination select: the address is placed only in the field that is not selected, and a strobe is sent on the field that is not selected. This separates the two compare paths. A disabled entry that would otherwise match, and transfers started from each endian trigger lane compared against writes that leave the trigger lane out, show whether the comparator follows the registers only when a trigger write occurs.

// File: rtl/mac_filt_pkg.sv
package mac_filt_pkg;
  localparam int MAC_W    = 48;
  localparam int MAC_B    = MAC_W / 8;
  localparam int WORD_W   = 32;
  localparam int WORD_B   = WORD_W / 8;
  localparam int HI_ADR_W = MAC_W - WORD_W;

  typedef struct packed {
    logic             en;
    logic             use_sa;
    logic [MAC_B-1:0] mask;
    logic [MAC_W-1:0] mac;
  } entry_t;

  localparam entry_t ENTRY_RST = '{en: 1'b0, use_sa: 1'b0, mask: '0, mac: '1};
endpackage

// File: rtl/mac_filt_regs.sv
module mac_filt_regs
  import mac_filt_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic              addr,
  input  logic [WORD_B-1:0] be,
  input  logic [WORD_W-1:0] wdata,
  input  logic              big_endian,
  output entry_t            entry,
  output logic              xfer_tgl,
  output logic [WORD_W-1:0] rdata
);
  logic [WORD_W-1:0] hi_word;
  logic [WORD_W-1:0] lo_word;
  logic              trig;

  assign hi_word = {entry.en, entry.use_sa, entry.mask, 8'h00, entry.mac[MAC_W-1:WORD_W]};
  assign lo_word = entry.mac[WORD_W-1:0];
  assign trig    = wr && addr && (big_endian ? be[0] : be[WORD_B-1]);

  always_ff @(posedge clk) begin
    if (rst) begin
      entry    <= ENTRY_RST;
      xfer_tgl <= 1'b0;
      rdata    <= '0;
    end else begin
      if (wr && !addr) begin
        if (be[3]) begin
          entry.en     <= wdata[31];
          entry.use_sa <= wdata[30];
          entry.mask   <= wdata[29:24];
        end
        for (int k = 0; k < HI_ADR_W / 8; k++)
          if (be[k]) entry.mac[WORD_W+8*k +: 8] <= wdata[8*k +: 8];
      end
      if (wr && addr) begin
        for (int k = 0; k < WORD_B; k++)
          if (be[k]) entry.mac[8*k +: 8] <= wdata[8*k +: 8];
      end
      if (trig) xfer_tgl <= ~xfer_tgl;
      rdata <= addr ? lo_word : hi_word;
    end
  end
endmodule

// File: rtl/mac_filt_xfer.sv
module mac_filt_xfer
  import mac_filt_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic   clk,
  input  logic   rst,
  input  logic   tgl_src,
  input  entry_t entry_src,
  output entry_t entry_dst,
  output logic   load
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   last_q;

  assign load = sync_q[SYNC_STAGES-1] ^ last_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q    <= '0;
      last_q    <= 1'b0;
      entry_dst <= ENTRY_RST;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], tgl_src};
      last_q <= sync_q[SYNC_STAGES-1];
      if (load) entry_dst <= entry_src;
    end
  end
endmodule

// File: rtl/mac_filt_cmp.sv
module mac_filt_cmp
  import mac_filt_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  entry_t           entry,
  input  logic [MAC_W-1:0] da,
  input  logic             da_vld,
  input  logic [MAC_W-1:0] sa,
  input  logic             sa_vld,
  output logic             hit_vld,
  output logic             hit
);
  logic [MAC_W-1:0] fld;
  logic             fld_vld;
  logic [MAC_B-1:0] byte_ok;

  assign fld     = entry.use_sa ? sa : da;
  assign fld_vld = entry.use_sa ? sa_vld : da_vld;

  for (genvar i = 0; i < MAC_B; i++) begin : g_byte
    assign byte_ok[i] = entry.mask[i] || (fld[8*i +: 8] == entry.mac[8*i +: 8]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hit_vld <= 1'b0;
      hit     <= 1'b0;
    end else begin
      hit_vld <= fld_vld;
      hit     <= fld_vld && entry.en && (&byte_ok);
    end
  end
endmodule

// File: rtl/mac_addr_filter.sv
module mac_addr_filter
  import mac_filt_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              cfg_clk,
  input  logic              cfg_rst,
  input  logic              cfg_wr,
  input  logic              cfg_addr,
  input  logic [WORD_B-1:0] cfg_be,
  input  logic [WORD_W-1:0] cfg_wdata,
  input  logic              cfg_big_endian,
  output logic [WORD_W-1:0] cfg_rdata,
  input  logic              rx_clk,
  input  logic              rx_rst,
  input  logic [MAC_W-1:0]  rx_da,
  input  logic              rx_da_vld,
  input  logic [MAC_W-1:0]  rx_sa,
  input  logic              rx_sa_vld,
  output logic              rx_hit_vld,
  output logic              rx_hit
);
  entry_t cfg_entry;
  entry_t rx_entry;
  logic   xfer_tgl;
  logic   rx_load;

  mac_filt_regs u_regs (
    .clk(cfg_clk), .rst(cfg_rst), .wr(cfg_wr), .addr(cfg_addr), .be(cfg_be),
    .wdata(cfg_wdata), .big_endian(cfg_big_endian), .entry(cfg_entry),
    .xfer_tgl(xfer_tgl), .rdata(cfg_rdata)
  );

  mac_filt_xfer #(.SYNC_STAGES(SYNC_STAGES)) u_xfer (
    .clk(rx_clk), .rst(rx_rst), .tgl_src(xfer_tgl), .entry_src(cfg_entry),
    .entry_dst(rx_entry), .load(rx_load)
  );

  mac_filt_cmp u_cmp (
    .clk(rx_clk), .rst(rx_rst), .entry(rx_entry), .da(rx_da), .da_vld(rx_da_vld),
    .sa(rx_sa), .sa_vld(rx_sa_vld), .hit_vld(rx_hit_vld), .hit(rx_hit)
  );
endmodule

// File: rtl/mac_addr_filter_chk.sv
module mac_addr_filter_chk
  import mac_filt_pkg::*;
(
  input logic              cfg_clk,
  input logic              cfg_rst,
  input logic              cfg_addr,
  input logic [WORD_W-1:0] cfg_rdata,
  input logic              rx_clk,
  input logic              rx_rst,
  input logic              rx_da_vld,
  input logic              rx_sa_vld,
  input logic              rx_hit_vld,
  input logic              rx_hit,
  input logic              rx_load,
  input entry_t            rx_entry
);
  AST_RSVD_ZERO: assert property (@(posedge cfg_clk) disable iff (cfg_rst)
    !$past(cfg_addr) |-> cfg_rdata[23:16] == 8'h00); // R3

  AST_NO_HIT_DISABLED: assert property (@(posedge rx_clk) disable iff (rx_rst)
    rx_hit |-> $past(rx_entry.en)); // R4

  AST_HIT_WITH_STROBE: assert property (@(posedge rx_clk) disable iff (rx_rst)
    rx_hit |-> rx_hit_vld); // R9

  AST_RESULT_AFTER_STROBE: assert property (@(posedge rx_clk) disable iff (rx_rst)
    rx_hit_vld |-> $past(rx_da_vld || rx_sa_vld)); // R9

  AST_ENTRY_HELD: assert property (@(posedge rx_clk) disable iff (rx_rst)
    !rx_load |=> $stable(rx_entry)); // R8

  AST_ALL_MASKED_HIT: assert property (@(posedge rx_clk) disable iff (rx_rst)
    (rx_entry.en && (&rx_entry.mask) && !rx_load &&
     (rx_entry.use_sa ? rx_sa_vld : rx_da_vld)) |=> rx_hit); // R7
endmodule

bind mac_addr_filter mac_addr_filter_chk u_chk (
  .cfg_clk(cfg_clk), .cfg_rst(cfg_rst), .cfg_addr(cfg_addr), .cfg_rdata(cfg_rdata),
  .rx_clk(rx_clk), .rx_rst(rx_rst), .rx_da_vld(rx_da_vld), .rx_sa_vld(rx_sa_vld),
  .rx_hit_vld(rx_hit_vld), .rx_hit(rx_hit), .rx_load(rx_load), .rx_entry(rx_entry)
);

// File: tb/mac_addr_filter_tb_top.sv
module mac_addr_filter_tb_top;
  localparam int CFG_PERIOD = 10;
  localparam int RX_PERIOD  = 14;
  localparam int WATCHDOG   = 150000;

  logic        cfg_clk = 0, cfg_rst = 1, cfg_wr = 0, cfg_addr = 0, cfg_big_endian = 0;
  logic [3:0]  cfg_be = 0;
  logic [31:0] cfg_wdata = 0, cfg_rdata;
  logic        rx_clk = 0, rx_rst = 1, rx_da_vld = 0, rx_sa_vld = 0, rx_hit_vld, rx_hit;
  logic [47:0] rx_da = 0, rx_sa = 0;

  int checks = 0, failures = 0;
  bit done = 0;

  always #(CFG_PERIOD/2) cfg_clk = ~cfg_clk;
  always #(RX_PERIOD/2)  rx_clk  = ~rx_clk;

  mac_addr_filter dut_i (.*);

  task automatic chk(input string req, input logic [47:0] act, input logic [47:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [3:0] be, input logic [31:0] d);
    @(negedge cfg_clk);
    cfg_wr = 1; cfg_addr = a; cfg_be = be; cfg_wdata = d;
    @(negedge cfg_clk);
    cfg_wr = 0; cfg_be = 0;
  endtask

  task automatic rd(input logic a, output logic [31:0] d);
    @(negedge cfg_clk); cfg_addr = a;
    @(negedge cfg_clk); d = cfg_rdata;
  endtask

  task automatic settle();
    repeat (8) @(negedge rx_clk);
  endtask

  task automatic prog(input logic en, input logic sel, input logic [5:0] m, input logic [47:0] mac);
    wr(0, 4'b1011, {en, sel, m, 8'h00, mac[47:32]});
    wr(1, 4'b1111, mac[31:0]);
    settle();
  endtask

  task automatic frame(input string req, input logic [47:0] da, input logic dv,
                       input logic [47:0] sa, input logic sv,
                       input logic exp_vld, input logic exp_hit);
    @(negedge rx_clk);
    rx_da = da; rx_da_vld = dv; rx_sa = sa; rx_sa_vld = sv;
    @(negedge rx_clk);
    rx_da_vld = 0; rx_sa_vld = 0;
    chk(req, {46'd0, rx_hit_vld, rx_hit}, {46'd0, exp_vld, exp_hit});
  endtask

  initial begin : wd
    repeat (WATCHDOG) @(posedge rx_clk);
    if (!done) begin
      failures++; checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] d;
    logic [47:0] mac, sa_other;
    repeat (3) @(negedge cfg_clk);
    cfg_rst = 0; rx_rst = 0;
    repeat (2) @(negedge rx_clk);

    chk("R1 rx idle after reset", {46'd0, rx_hit_vld, rx_hit}, 48'd0);
    rd(0, d); chk("R1 high reset", {16'd0, d}, 48'h0000_0000_FFFF);
    rd(1, d); chk("R1 low reset", {16'd0, d}, 48'h0000_FFFF_FFFF);

    wr(0, 4'b1111, 32'hC5FF_1234); rd(0, d);
    chk("R3 reserved bits read zero", {16'd0, d}, 48'h0000_C500_1234);
    wr(0, 4'b0100, 32'h0000_0000); rd(0, d);
    chk("R2 unselected bytes kept", {16'd0, d}, 48'h0000_C500_1234);
    wr(1, 4'b0101, 32'hAA11_BB22); rd(1, d);
    chk("R2 low byte enables", {16'd0, d}, 48'h0000_FF11_FF22);

    mac = 48'h0A1B_2C3D_4E5F;
    for (int m = 0; m < 64; m++) begin
      prog(1, 0, m[5:0], mac ^ {42'd0, m[5:0]} << 0);
      for (int b = -1; b < 6; b++) begin
        logic [47:0] f;
        logic eh;
        f = mac ^ {42'd0, m[5:0]};
        eh = 1;
        if (b >= 0) begin
          f[8*b +: 8] = ~f[8*b +: 8];
          eh = m[b];
        end
        frame(b < 0 ? "R6 exact match" : "R6 byte mismatch vs mask", f, 1, 48'd0, 0, 1, eh);
      end
    end

    prog(1, 0, 6'h3F, mac);
    frame("R7 all masked any DA", 48'h1234_5678_9ABC, 1, 48'd0, 0, 1, 1);
    frame("R7 all masked zero DA", 48'h0, 1, 48'd0, 0, 1, 1);

    prog(0, 0, 6'h00, mac);
    frame("R4 disabled exact DA", mac, 1, mac, 1, 1, 0);

    sa_other = 48'h0000_0000_0001;
    prog(1, 0, 6'h00, mac);
    frame("R5 DA select uses DA", mac, 1, sa_other, 1, 1, 1);
    frame("R5 DA select ignores SA", sa_other, 1, mac, 1, 1, 0);
    frame("R5 SA strobe alone no result", mac, 0, mac, 1, 0, 0);
    prog(1, 1, 6'h00, mac);
    frame("R5 SA select uses SA", sa_other, 1, mac, 1, 1, 1);
    frame("R5 SA select ignores DA", mac, 1, sa_other, 1, 1, 0);
    frame("R9 DA strobe alone no result", mac, 1, mac, 0, 0, 0);

    prog(1, 0, 6'h00, mac);
    wr(0, 4'b1011, {8'h80, 8'h00, 16'h7777});
    wr(1, 4'b0111, 32'h0066_5544);
    settle();
    frame("R8 no trigger lane keeps old", mac, 1, 48'd0, 0, 1, 1);
    wr(1, 4'b1000, 32'h3300_0000);
    settle();
    frame("R8 lane3 trigger loads new", 48'h7777_3366_5544, 1, 48'd0, 0, 1, 1);
    frame("R8 old address dropped", mac, 1, 48'd0, 0, 1, 0);

    cfg_big_endian = 1;
    wr(0, 4'b0011, 32'h0000_0102);
    wr(1, 4'b1000, 32'h0300_0000);
    settle();
    frame("R8 lane3 no trigger big endian", 48'h7777_3366_5544, 1, 48'd0, 0, 1, 1);
    wr(1, 4'b0001, 32'h0000_0006);
    settle();
    frame("R8 lane0 trigger big endian", 48'h0102_0366_5506, 1, 48'd0, 0, 1, 1);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule